// File: doc/BRIEF.md
# Predicated Scatter Byte Store Sequencer

This block accepts a single vector store command and turns it into a sequence of one-byte memory writes. A command has five parts: a data vector, a vector of per-element base addresses, a predicate with one bit per vector byte, an element-size select (32 or 64 bits) and an unsigned 5-bit immediate. Each active element produces one write. The write's address is that element's base, zero-extended to 64 bits, plus the immediate. The write's data is the low byte of the matching data element.

All command fields are captured when start is accepted. The writes then leave the block one at a time on a valid/ready port, lowest element index first. Inactive elements cost no cycles. The number of cycles and the order of the writes depend only on the predicate and the ready pattern, never on the data or address values. The vector length is a parameter.

Top module: `scatter_byte_store`

## Requirements
- R1: After reset, busy_o, done_o and wr_valid_o are low.
- R2: Element-size select esz64_i = 0 means 32-bit elements, numbered 0 to VLEN_BITS/32-1. Element e is active when pred_i bit 4e is set. esz64_i = 1 means 64-bit elements, numbered 0 to VLEN_BITS/64-1. Element e is active when pred_i bit 8e is set. No other predicate bit has any effect.
- R3: The write address of element e is its base field zero-extended to 64 bits plus imm_i (0..31), taken modulo 2^64. The base field is base_i bits [32e+31:32e] for 32-bit elements and [64e+63:64e] for 64-bit elements.
- R4: The write data of element e is bits [8e'+7:8e'] of data_i, where e' is the element's starting bit divided by 8. This is the low byte of the element.
- R5: Each active element produces exactly one write, in ascending element order. Inactive elements produce no write.
- R6: While wr_valid_o is high and wr_ready_i is low, wr_valid_o, wr_addr_o and wr_data_o hold their values.
- R7: busy_o rises the cycle after an accepted start with at least one active element, and it falls the cycle after the last write is accepted. done_o is high for exactly that one cycle. wr_valid_o is never high while busy_o is low.
- R8: A start with no active element produces no write and leaves busy_o low. done_o pulses in the cycle after the start.
- R9: A start while busy_o is high is ignored. Input changes after an accepted start have no effect on the writes in progress.
- R10: With wr_ready_i held high and k active elements, writes are valid in cycles 1..k after the start and done_o is high in cycle k+1, whatever the data and base values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request, taken when idle |
| esz64_i | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| imm_i | input | 5 | Unsigned byte offset added to every address |
| pred_i | input | VLEN_BITS/8 | Per-byte predicate |
| data_i | input | VLEN_BITS | Store data vector |
| base_i | input | VLEN_BITS | Base address vector |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_valid_o | output | 1 | Byte write request |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_addr_o | output | 64 | Byte write address |
| wr_data_o | output | 8 | Byte write data |

## Verification
The bench builds the block with VLEN_BITS = 128. That gives four 32-bit elements or two 64-bit elements, so every element position and every predicate bit, including the ones R2 says are ignored, can be driven by hand. At this width the address-wrap and zero-extension cases, the empty-predicate path, stalls on the first and the last write, and a start arriving in the middle of a command all fit within short directed runs.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int ADDR_W = 64;
  localparam int BYTE_W = 8;
  localparam int IMM_W  = 5;

  typedef enum logic {
    ESZ_32 = 1'b0,
    ESZ_64 = 1'b1
  } esz_e;
endpackage

// File: rtl/sbs_act_mask.sv
module sbs_act_mask
  import sbs_pkg::*;
#(
  parameter int VLEN_BITS = 256
) (
  input  logic [VLEN_BITS/8-1:0]  pred_i,
  input  esz_e                    esz_i,
  output logic [VLEN_BITS/32-1:0] act_o
);
  localparam int NE   = VLEN_BITS / 32;
  localparam int NE64 = VLEN_BITS / 64;

  logic [NE-1:0] act32, act64;

  for (genvar e = 0; e < NE; e++) begin : g_el
    assign act32[e] = pred_i[4*e];
    if (e < NE64) begin : g_w
      assign act64[e] = pred_i[8*e];
    end else begin : g_n
      assign act64[e] = 1'b0;
    end
  end

  assign act_o = (esz_i == ESZ_64) ? act64 : act32;
endmodule

// File: rtl/sbs_first_set.sv
module sbs_first_set #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  assign any_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/sbs_lane_sel.sv
module sbs_lane_sel
  import sbs_pkg::*;
#(
  parameter int VLEN_BITS = 256,
  parameter int IW        = 3
) (
  input  logic [VLEN_BITS-1:0] data_i,
  input  logic [VLEN_BITS-1:0] base_i,
  input  esz_e                 esz_i,
  input  logic [IMM_W-1:0]     imm_i,
  input  logic [IW-1:0]        idx_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [BYTE_W-1:0]    byte_o
);
  localparam int NE   = VLEN_BITS / 32;
  localparam int NE64 = VLEN_BITS / 64;

  logic [ADDR_W-1:0] a32 [NE];
  logic [ADDR_W-1:0] a64 [NE];
  logic [BYTE_W-1:0] d32 [NE];
  logic [BYTE_W-1:0] d64 [NE];

  for (genvar e = 0; e < NE; e++) begin : g_ln
    assign a32[e] = {{(ADDR_W-32){1'b0}}, base_i[32*e +: 32]};
    assign d32[e] = data_i[32*e +: BYTE_W];
    if (e < NE64) begin : g_w
      assign a64[e] = base_i[64*e +: 64];
      assign d64[e] = data_i[64*e +: BYTE_W];
    end else begin : g_n
      assign a64[e] = '0;
      assign d64[e] = '0;
    end
  end

  logic [ADDR_W-1:0] base_sel;
  assign base_sel = (esz_i == ESZ_64) ? a64[idx_i] : a32[idx_i];
  assign byte_o   = (esz_i == ESZ_64) ? d64[idx_i] : d32[idx_i];
  // wraps mod 2^ADDR_W
  assign addr_o   = base_sel + {{(ADDR_W-IMM_W){1'b0}}, imm_i};
endmodule

// File: rtl/scatter_byte_store.sv
module scatter_byte_store
  import sbs_pkg::*;
#(
  parameter int VLEN_BITS = 256
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   esz64_i,
  input  logic [IMM_W-1:0]       imm_i,
  input  logic [VLEN_BITS/8-1:0] pred_i,
  input  logic [VLEN_BITS-1:0]   data_i,
  input  logic [VLEN_BITS-1:0]   base_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   wr_valid_o,
  input  logic                   wr_ready_i,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [BYTE_W-1:0]      wr_data_o
);
  localparam int NE = VLEN_BITS / 32;
  localparam int IW = (NE > 1) ? $clog2(NE) : 1;

  esz_e                 esz_in;
  logic [NE-1:0]        act_w;
  logic [NE-1:0]        pend_q, pend_nxt;
  logic [IW-1:0]        idx_w;
  logic                 any_w;
  logic                 busy_q, done_q;
  esz_e                 esz_q;
  logic [IMM_W-1:0]     imm_q;
  logic [VLEN_BITS-1:0] data_q, base_q;

  assign esz_in = esz_e'(esz64_i);

  sbs_act_mask #(.VLEN_BITS(VLEN_BITS)) u_mask (
    .pred_i (pred_i),
    .esz_i  (esz_in),
    .act_o  (act_w)
  );

  sbs_first_set #(.N(NE), .IW(IW)) u_pick (
    .vec_i (pend_q),
    .idx_o (idx_w),
    .any_o (any_w)
  );

  sbs_lane_sel #(.VLEN_BITS(VLEN_BITS), .IW(IW)) u_lane (
    .data_i (data_q),
    .base_i (base_q),
    .esz_i  (esz_q),
    .imm_i  (imm_q),
    .idx_i  (idx_w),
    .addr_o (wr_addr_o),
    .byte_o (wr_data_o)
  );

  assign pend_nxt = pend_q & ~(NE'(1) << idx_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
      esz_q  <= ESZ_32;
      imm_q  <= '0;
      data_q <= '0;
      base_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          esz_q  <= esz_in;
          imm_q  <= imm_i;
          data_q <= data_i;
          base_q <= base_i;
          pend_q <= act_w;
          if (|act_w) busy_q <= 1'b1;
          else        done_q <= 1'b1;
        end
      end else if (wr_ready_i) begin
        pend_q <= pend_nxt;
        if (pend_nxt == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign wr_valid_o = busy_q & any_w;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int VLEN_BITS = 256,
  parameter int NE        = VLEN_BITS / 32,
  parameter int IW        = (NE > 1) ? $clog2(NE) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [63:0]   wr_addr_o,
  input logic [7:0]    wr_data_o,
  input logic [NE-1:0] act_i,
  input logic [IW-1:0] idx_i
);
  assert_no_write_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_valid_o);

  assert_hold_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_done_at_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_empty_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (act_i == '0) |=> done_o && !busy_o);

  assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(wr_valid_o && wr_ready_i) |=> busy_o && $stable(wr_addr_o));

  assert_ascending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && wr_ready_i |=> !wr_valid_o || (idx_i > $past(idx_i)));
endmodule

bind scatter_byte_store sbs_checker #(.VLEN_BITS(VLEN_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .act_i      (act_w),
  .idx_i      (idx_w)
);

// File: tb/sim_scatter_byte_store.sv
`timescale 1ns/1ps
module sim_scatter_byte_store;
  localparam int VL = 128;
  localparam int PW = VL / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          esz64 = 1'b0;
  logic [4:0]    imm = '0;
  logic [PW-1:0] pred = '0;
  logic [VL-1:0] data = '0;
  logic [VL-1:0] base = '0;
  logic          busy, done, wvalid;
  logic          wready = 1'b1;
  logic [63:0]   waddr;
  logic [7:0]    wdata;

  always #2.5 clk = ~clk;

  scatter_byte_store #(.VLEN_BITS(VL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .esz64_i(esz64), .imm_i(imm),
    .pred_i(pred), .data_i(data), .base_i(base), .busy_o(busy), .done_o(done),
    .wr_valid_o(wvalid), .wr_ready_i(wready), .wr_addr_o(waddr), .wr_data_o(wdata)
  );

  int checks = 0, errors = 0;
  logic [63:0] exp_a [4];
  logic [7:0]  exp_d [4];
  int          exp_n;
  logic [63:0] got_a [8];
  logic [7:0]  got_d [8];
  int          got_n, done_cyc, first_valid, hold_err, late_pulse;
  logic        busy_seen_1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference from requirements R2, R3, R4
  task automatic model(input logic e64, input logic [4:0] im, input logic [PW-1:0] p,
                       input logic [VL-1:0] d, input logic [VL-1:0] b);
    int ne;
    int step;
    ne = e64 ? VL/64 : VL/32;
    step = e64 ? 8 : 4;
    exp_n = 0;
    for (int e = 0; e < ne; e++) begin
      if (p[e*step]) begin
        if (e64) exp_a[exp_n] = b[64*e +: 64] + 64'(im);
        else     exp_a[exp_n] = {32'h0, b[32*e +: 32]} + 64'(im);
        exp_d[exp_n] = e64 ? d[64*e +: 8] : d[32*e +: 8];
        exp_n++;
      end
    end
  endtask

  // stall: 0 = ready high, 1 = ready every third cycle
  task automatic run(input logic e64, input logic [4:0] im, input logic [PW-1:0] p,
                     input logic [VL-1:0] d, input logic [VL-1:0] b,
                     input int stall, input bit inject);
    logic        prev_st;
    logic [63:0] pa;
    logic [7:0]  pd;
    model(e64, im, p, d, b);
    @(negedge clk);
    esz64 = e64; imm = im; pred = p; data = d; base = b; start = 1'b1;
    got_n = 0; done_cyc = -1; first_valid = -1; hold_err = 0; prev_st = 1'b0;
    busy_seen_1 = 1'b0; late_pulse = 0;
    pa = '0; pd = '0;
    for (int cyc = 1; cyc < 100; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (cyc == 1) busy_seen_1 = busy;
      if (inject && cyc == 2) begin
        start = 1'b1; esz64 = ~e64; imm = im + 5'd3; pred = ~p; data = ~d; base = ~b;
      end
      if (done) begin done_cyc = cyc; break; end
      wready = (stall == 0) ? 1'b1 : ((cyc % 3) == 0);
      if (prev_st && !(wvalid && waddr == pa && wdata == pd)) hold_err++;
      if (wvalid && first_valid < 0) first_valid = cyc;
      if (wvalid && wready && got_n < 8) begin
        got_a[got_n] = waddr; got_d[got_n] = wdata; got_n++;
      end
      prev_st = wvalid && !wready;
      pa = waddr; pd = wdata;
    end
    start = 1'b0;
    wready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done || busy || wvalid) late_pulse++;
    end
  endtask

  task automatic cmp_writes(input string req);
    chk(got_n == exp_n, req, "write count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_a[i] == exp_a[i], req, $sformatf("addr %0d", i), got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], req, $sformatf("data %0d", i), got_d[i], exp_d[i]);
    end
    chk(done_cyc > 0, req, "done seen", done_cyc, 1);
    chk(late_pulse == 0, "R7", "idle after done", late_pulse, 0);
    chk(hold_err == 0, "R6", "hold while stalled", hold_err, 0);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(wvalid == 0, "R1", "valid", wvalid, 0);
  endtask

  task automatic t_full32;
    run(1'b0, 5'd5, 16'h1111, 128'hA4A3A2A1_B4B3B2B1_C4C3C2C1_D4D3D2D1,
        128'h00004000_00003000_00002000_00001000, 0, 1'b0);
    cmp_writes("R3 R4 R5");
    chk(first_valid == 1, "R10", "first valid cycle", first_valid, 1);
    chk(done_cyc == 5, "R10", "done cycle", done_cyc, 5);
    chk(busy_seen_1 == 1'b1, "R7", "busy after start", busy_seen_1, 1);
  endtask

  task automatic t_noise64_stall;
    run(1'b1, 5'd0, 16'h01FF, 128'h1111_2222_3333_4455_6666_7777_8888_99AA,
        128'h0000_0001_0000_0100_0000_0000_8000_0010, 1, 1'b0);
    cmp_writes("R2 R6");
    chk(exp_n == 2, "R2", "model active count", exp_n, 2);
  endtask

  task automatic t_empty;
    run(1'b0, 5'd7, 16'hEEEE, '1, '1, 0, 1'b0);
    cmp_writes("R8 R2");
    chk(done_cyc == 1, "R8", "done cycle", done_cyc, 1);
    chk(busy_seen_1 == 1'b0, "R8", "busy stays low", busy_seen_1, 0);
    chk(first_valid == -1, "R8", "no valid", first_valid, -1);
  endtask

  task automatic t_wrap;
    run(1'b1, 5'd31, 16'h0101, 128'h0,
        128'h0000_0000_0000_0020_FFFF_FFFF_FFFF_FFF0, 0, 1'b0);
    cmp_writes("R3");
    chk(got_a[0] == 64'h0F, "R3", "wrap addr", got_a[0], 64'h0F);
    run(1'b0, 5'd31, 16'h0001, 128'h0, 128'hFFFF_FFF0, 0, 1'b0);
    cmp_writes("R3");
    chk(got_a[0] == 64'h1_0000_000F, "R3", "zero-extend addr", got_a[0], 64'h1_0000_000F);
  endtask

  task automatic t_sparse_order;
    run(1'b0, 5'd1, 16'h1010, 128'h00000044_00000033_00000022_00000011,
        128'h00000400_00000300_00000200_00000100, 1, 1'b0);
    cmp_writes("R5");
    chk(got_a[0] == 64'h201 && got_a[1] == 64'h401, "R5", "ascending", got_a[0], 64'h201);
  endtask

  task automatic t_busy_start;
    run(1'b0, 5'd2, 16'h1111, 128'h0D0C0B0A_09080706_05040302_01000F0E,
        128'h00000040_00000030_00000020_00000010, 0, 1'b1);
    cmp_writes("R9");
    chk(done_cyc == 5, "R9", "done cycle unchanged", done_cyc, 5);
  endtask

  task automatic t_timing;
    int c0;
    run(1'b1, 5'd9, 16'h0101, '0, '0, 0, 1'b0);
    c0 = done_cyc;
    run(1'b1, 5'd9, 16'h0101, '1, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_0F0F_F0F0, 0, 1'b0);
    cmp_writes("R10");
    chk(done_cyc == c0, "R10", "cycles data-independent", done_cyc, c0);
    chk(done_cyc == 3, "R10", "done cycle", done_cyc, 3);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full32();
        t_noise64_stall();
        t_empty();
        t_wrap();
        t_sparse_order();
        t_busy_start();
        t_timing();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule